// File: doc/BRIEF.md
# Angle Bus Read Controller

This block sits in the host logic and fetches a 16-bit shaft angle from a tracking converter whose update activity runs with no relation to the local clock. A request arrives as an asynchronous level. The block brings it into the clock domain and drives a single active-low hold line, which freezes the converter's output latch and enables its bus drivers at the same time. It then captures the bus and returns the angle with a one-cycle valid pulse.

Two read modes are offered. In settle mode the hold line stays low for a window long enough to cover the converter's worst-case data settling time. The bus is sampled on the falling clock edge of the last held cycle, half a cycle away from the rising edge at which the hold line is released. In compare mode the converter's update activity is not relied on at all. The block makes two short reads a fixed gap apart and accepts the value only if the two agree, optionally disregarding bit 0. A disagreement causes a retry. After a bounded number of retries the block raises an error flag instead of returning a value.

All window lengths are given in nanoseconds together with the clock frequency in kHz. The block converts them to clock cycles, rounding up.

Top module: `angle_read_ctrl`

## Requirements
- R1: After reset, holdN is 1, angleValid is 0, readErr is 0 and angleOut is 0.
- R2: A rising edge on reqAsync, passed through a two-flop synchroniser, starts a read when the block is idle, which drives holdN low.
- R3: In settle mode (cmpMode=0), holdN stays low for exactly ceil(SETTLE_NS*CLK_KHZ/10^6) clock cycles, which is 50 with the default parameters, and falls only once per read.
- R4: In settle mode, angleOut takes the value the bus presented while holdN was low. The capture happens on the falling clock edge of the last held cycle, and angleValid pulses on the cycle after holdN returns high.
- R5: In compare mode (cmpMode=1), each read pair lowers holdN twice. Each low phase lasts ceil(ENABLE_NS*CLK_KHZ/10^6) cycles, which is 9 with the default parameters, and the two phases are separated by ceil(GAP_NS*CLK_KHZ/10^6) released cycles. Two equal samples publish that value.
- R6: With ignoreLsb=1, compare mode treats samples that differ only in bit 0 as equal and publishes the second sample. A difference in any other bit is still a mismatch.
- R7: A mismatching pair is retried, up to MAX_RETRY further pairs (default 2, so 6 holdN pulses in total). If the last pair also mismatches, readErr goes to 1 and no angleValid is produced. readErr stays at 1 until the next read is accepted, which clears it.
- R8: A reqAsync rising edge that arrives while a read is in progress starts no additional read and produces no additional result.
- R9: angleValid lasts exactly one cycle per successful read, and angleOut holds its value until the next successful read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqAsync | input | 1 | Read request, asynchronous; its rising edge starts a read |
| cmpMode | input | 1 | 0 selects settle mode, 1 selects compare mode; latched at the start of each read |
| ignoreLsb | input | 1 | In compare mode, excludes bit 0 from the equality test |
| dataIn | input | DATA_W | Converter angle bus |
| holdN | output | 1 | Combined active-low inhibit and output-enable line to the converter |
| angleOut | output | DATA_W | Last angle accepted |
| angleValid | output | 1 | One-cycle pulse when angleOut is updated |
| readErr | output | 1 | Set when compare retries are exhausted; cleared by the next accepted request |

## Verification
The interesting collision is a fresh request edge landing while a read is still in flight. In that cycle, request detection and the hold-window logic both act on the same state. The bench provokes this by dropping and re-raising reqAsync in the middle of a settle-mode hold window. It then counts hold-line falls and scoreboard results over a long quiet window afterwards, and accepts the run only if it sees exactly one fall and one result. A second overlap occurs when the retry limit expires while the error flag and the valid path both come from the last comparison. The bench forces every pair to mismatch and checks that the error comes with no valid pulse.

// File: rtl/angle_rd_pkg.sv
package angle_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HOLD,
    S_GAP,
    S_CHECK,
    S_PUB
  } rdState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capA;     // capture first sample of a compare pair
    logic capB;     // capture the single / second sample
    logic publish;  // move second sample to the output
    logic cmpRun;   // current read is in compare mode
  } rdStrobe_t;

endpackage

// File: rtl/angle_rd_ctrl.sv
module angle_rd_ctrl
  import angle_rd_pkg::*;
#(
  parameter int SETTLE_CYC = 50,
  parameter int ENA_CYC    = 9,
  parameter int GAP_CYC    = 125,
  parameter int MAX_RETRY  = 2,
  parameter int CNT_W      = 8,
  parameter int RTY_W      = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqAsync,
  input  logic      cmpMode,
  input  logic      match,
  output logic      holdN,
  output rdStrobe_t stb,
  output logic      readErr
);

  logic [1:0]       reqSync;
  logic             reqPrev;
  logic             reqRise;
  rdState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] holdLim;
  logic [RTY_W-1:0] rtyCnt;
  logic             phaseB;
  logic             modeCmp;
  logic             lastHold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqSync <= '0;
      reqPrev <= 1'b0;
    end else begin
      reqSync <= {reqSync[0], reqAsync};
      reqPrev <= reqSync[1];
    end
  end

  assign reqRise  = reqSync[1] & ~reqPrev;
  assign holdLim  = modeCmp ? CNT_W'(ENA_CYC) : CNT_W'(SETTLE_CYC);
  assign lastHold = (state == S_HOLD) && (cnt == holdLim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      rtyCnt  <= '0;
      phaseB  <= 1'b0;
      modeCmp <= 1'b0;
      readErr <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (reqRise) begin
            state   <= S_HOLD;
            cnt     <= '0;
            rtyCnt  <= '0;
            phaseB  <= 1'b0;
            modeCmp <= cmpMode;
            readErr <= 1'b0;
          end
        end
        S_HOLD: begin
          if (lastHold) begin
            cnt <= '0;
            if (!modeCmp) begin
              state <= S_PUB;
            end else if (!phaseB) begin
              phaseB <= 1'b1;
              state  <= S_GAP;
            end else begin
              state <= S_CHECK;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GAP: begin
          if (cnt == CNT_W'(GAP_CYC - 1)) begin
            cnt   <= '0;
            state <= S_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CHECK: begin
          if (match) begin
            state <= S_PUB;
          end else if (rtyCnt == RTY_W'(MAX_RETRY)) begin
            readErr <= 1'b1;
            state   <= S_IDLE;
          end else begin
            rtyCnt <= rtyCnt + 1'b1;
            phaseB <= 1'b0;
            cnt    <= '0;
            state  <= S_GAP;
          end
        end
        S_PUB:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign holdN       = (state != S_HOLD);
  assign stb.capA    = lastHold & modeCmp & ~phaseB;
  assign stb.capB    = lastHold & (~modeCmp | phaseB);
  assign stb.publish = (state == S_PUB);
  assign stb.cmpRun  = modeCmp;

  // Checker state: length of the current low phase of holdN
  logic [CNT_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lowCnt <= '0;
    else if (!holdN) lowCnt <= lowCnt + 1'b1;
    else            lowCnt <= '0;
  end

  // R3 R5
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdN) |-> (lowCnt == holdLim));

  // R8
  hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdN) |-> ($past(state) == S_IDLE || $past(state) == S_GAP));

endmodule

// File: rtl/angle_rd_dpath.sv
module angle_rd_dpath
  import angle_rd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rdStrobe_t         stb,
  input  logic              ignoreLsb,
  input  logic [DATA_W-1:0] dataIn,
  output logic              match,
  output logic [DATA_W-1:0] angleOut,
  output logic              angleValid
);

  logic [DATA_W-1:0] firstReg;
  logic [DATA_W-1:0] secondReg;
  logic [DATA_W-1:0] cmpMask;

  // Capture on the edge opposite to the one that moves the hold line
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      firstReg  <= '0;
      secondReg <= '0;
    end else begin
      if (stb.capA) firstReg  <= dataIn;
      if (stb.capB) secondReg <= dataIn;
    end
  end

  assign cmpMask = ignoreLsb ? {{(DATA_W-1){1'b1}}, 1'b0} : {DATA_W{1'b1}};
  assign match   = ((firstReg ^ secondReg) & cmpMask) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      angleOut   <= '0;
      angleValid <= 1'b0;
    end else begin
      angleValid <= stb.publish;
      if (stb.publish) angleOut <= secondReg;
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    angleValid |=> !angleValid);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !angleValid |-> $stable(angleOut));

  // R5
  pub_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.publish && stb.cmpRun) |-> match);

endmodule

// File: rtl/angle_read_ctrl.sv
module angle_read_ctrl
  import angle_rd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CLK_KHZ   = 125000,
  parameter int SETTLE_NS = 400,
  parameter int ENABLE_NS = 70,
  parameter int GAP_NS    = 1000,
  parameter int MAX_RETRY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqAsync,
  input  logic              cmpMode,
  input  logic              ignoreLsb,
  input  logic [DATA_W-1:0] dataIn,
  output logic              holdN,
  output logic [DATA_W-1:0] angleOut,
  output logic              angleValid,
  output logic              readErr
);

  localparam int SETTLE_CYC = (SETTLE_NS * CLK_KHZ + 999999) / 1000000;
  localparam int ENA_CYC    = (ENABLE_NS * CLK_KHZ + 999999) / 1000000;
  localparam int GAP_CYC    = (GAP_NS * CLK_KHZ + 999999) / 1000000;
  localparam int MAX_CYC    = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int RTY_W      = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  rdStrobe_t stb;
  logic      match;

  angle_rd_ctrl #(
    .SETTLE_CYC(SETTLE_CYC),
    .ENA_CYC   (ENA_CYC),
    .GAP_CYC   (GAP_CYC),
    .MAX_RETRY (MAX_RETRY),
    .CNT_W     (CNT_W),
    .RTY_W     (RTY_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqAsync(reqAsync),
    .cmpMode (cmpMode),
    .match   (match),
    .holdN   (holdN),
    .stb     (stb),
    .readErr (readErr)
  );

  angle_rd_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .ignoreLsb (ignoreLsb),
    .dataIn    (dataIn),
    .match     (match),
    .angleOut  (angleOut),
    .angleValid(angleValid)
  );

  // R7
  err_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(readErr) |-> !angleValid);

  // R4
  valid_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    angleValid |-> holdN);

endmodule

// File: tb/tb_angle_read_ctrl.sv
module tb_angle_read_ctrl;

  localparam int SETTLE_LEN = 50;   // ceil(400 ns * 125 MHz)
  localparam int ENA_LEN    = 9;    // ceil(70 ns * 125 MHz)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqAsync = 1'b0;
  logic        cmpMode = 1'b0;
  logic        ignoreLsb = 1'b0;
  logic [15:0] dataIn;
  logic        holdN;
  logic [15:0] angleOut;
  logic        angleValid;
  logic        readErr;

  always #4 clk = ~clk;

  angle_read_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reqAsync(reqAsync), .cmpMode(cmpMode),
    .ignoreLsb(ignoreLsb), .dataIn(dataIn), .holdN(holdN),
    .angleOut(angleOut), .angleValid(angleValid), .readErr(readErr)
  );

  // Converter model: bus follows the live angle, frozen while held
  logic [15:0] liveAngle = 16'h0;
  logic [15:0] frozen = 16'h0;
  bit          jitLsb = 0;
  bit          jitBig = 0;
  int          fallCnt = 0;
  assign dataIn = holdN ? liveAngle : frozen;

  always @(negedge holdN) begin
    if (jitLsb) liveAngle = liveAngle ^ 16'h1;
    if (jitBig) liveAngle = liveAngle + 16'd4;
    frozen = liveAngle;
    fallCnt++;
  end

  int lowRun = 0;
  int lastLow = 0;
  always @(negedge clk) begin
    if (!holdN) lowRun++;
    else if (lowRun != 0) begin
      lastLow = lowRun;
      lowRun = 0;
    end
  end

  int nChecks = 0;
  int nFails = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [15:0] angle;
    bit          err;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  int results = 0;
  int validRun = 0;
  int maxValidRun = 0;
  logic errPrev = 1'b0;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (angleValid) begin
      validRun++;
      if (validRun > maxValidRun) maxValidRun = validRun;
    end else validRun = 0;
    if (angleValid || (readErr && !errPrev)) begin
      results++;
      if (expQ.size() == 0) begin
        check(0, "R8 unexpected result", int'(angleOut), 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (e.err) begin
          check(readErr && !angleValid, {e.tag, " error flag"}, int'(readErr), 1);
        end else begin
          check(angleValid && angleOut == e.angle, {e.tag, " angle"},
                int'(angleOut), int'(e.angle));
          check(!readErr, {e.tag, " no error"}, int'(readErr), 0);
        end
      end
    end
    errPrev = readErr;
  end

  task automatic doRead(input logic [15:0] expAngle, input bit expErr,
                        input int expFalls, input int expLow,
                        input bit extraPulse, input string tag);
    int f0;
    int r0;
    int waitCnt;
    expItem_t e;
    e.angle = expAngle; e.err = expErr; e.tag = tag;
    expQ.push_back(e);
    f0 = fallCnt;
    r0 = results;
    @(negedge clk) reqAsync = 1'b1;
    repeat (4) @(negedge clk);
    reqAsync = 1'b0;
    if (extraPulse) begin
      while (holdN) @(negedge clk);
      repeat (10) @(negedge clk);
      reqAsync = 1'b1;
      repeat (4) @(negedge clk);
      reqAsync = 1'b0;
    end
    waitCnt = 0;
    while (results == r0 && waitCnt < 5000) begin
      @(negedge clk);
      waitCnt++;
    end
    if (results == r0) begin
      check(0, {tag, " watchdog"}, waitCnt, 0);
      void'(expQ.pop_front());
    end
    repeat (5) @(negedge clk);
    check(fallCnt - f0 == expFalls, {tag, " hold pulses"}, fallCnt - f0, expFalls);
    check(lastLow == expLow, {tag, " hold length"}, lastLow, expLow);
  endtask

  int cycleCnt = 0;
  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt == 150000) begin
      check(0, "watchdog expired", cycleCnt, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(holdN == 1'b1, "R1 holdN", int'(holdN), 1);
    check(angleValid == 1'b0, "R1 angleValid", int'(angleValid), 0);
    check(readErr == 1'b0, "R1 readErr", int'(readErr), 0);
    check(angleOut == 16'h0, "R1 angleOut", int'(angleOut), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R4: settle mode, several bus patterns
    liveAngle = 16'h1234;
    doRead(16'h1234, 0, 1, SETTLE_LEN, 0, "R2 R3 R4 settle 1234");
    liveAngle = 16'hFFFF;
    doRead(16'hFFFF, 0, 1, SETTLE_LEN, 0, "R4 settle FFFF");
    liveAngle = 16'h0000;
    doRead(16'h0000, 0, 1, SETTLE_LEN, 0, "R4 settle 0000");

    // R9: output held after the pulse
    repeat (20) @(negedge clk);
    check(angleOut == 16'h0000 && !angleValid, "R9 hold between reads", int'(angleOut), 0);
    liveAngle = 16'h8001;
    doRead(16'h8001, 0, 1, SETTLE_LEN, 0, "R9 settle 8001");
    check(maxValidRun == 1, "R9 valid width", maxValidRun, 1);

    // R5: compare mode, steady angle
    cmpMode = 1'b1;
    liveAngle = 16'hA5A5;
    doRead(16'hA5A5, 0, 2, ENA_LEN, 0, "R5 compare steady");

    // R6: bit 0 toggles between reads, masked
    ignoreLsb = 1'b1;
    jitLsb = 1;
    liveAngle = 16'h2000;
    doRead(16'h2000, 0, 2, ENA_LEN, 0, "R6 lsb ignored");

    // R7: bit 0 toggles, not masked -> retries exhausted
    ignoreLsb = 1'b0;
    liveAngle = 16'h3000;
    doRead(16'h0, 1, 6, ENA_LEN, 0, "R7 retries exhausted");
    repeat (30) @(negedge clk);
    check(readErr == 1'b1, "R7 error sticky", int'(readErr), 1);
    check(angleOut == 16'h2000, "R7 output unchanged", int'(angleOut), 16'h2000);

    // R6: higher bit changes still mismatch when bit 0 is masked
    jitLsb = 0;
    jitBig = 1;
    ignoreLsb = 1'b1;
    liveAngle = 16'h4000;
    doRead(16'h0, 1, 6, ENA_LEN, 0, "R6 upper bits compared");

    // R7: next accepted read clears the error
    jitBig = 0;
    ignoreLsb = 1'b0;
    liveAngle = 16'h0F0F;
    doRead(16'h0F0F, 0, 2, ENA_LEN, 0, "R7 error cleared");
    check(readErr == 1'b0, "R7 readErr low", int'(readErr), 0);

    // R8: second request edge mid-read is ignored
    cmpMode = 1'b0;
    liveAngle = 16'h5A5A;
    begin
      int f1;
      int r1;
      f1 = fallCnt;
      doRead(16'h5A5A, 0, 1, SETTLE_LEN, 1, "R8 overlap request");
      r1 = results;
      repeat (300) @(negedge clk);
      check(fallCnt - f1 == 1, "R8 no restart", fallCnt - f1, 1);
      check(results == r1, "R8 no extra result", results - r1, 0);
    end

    check(expQ.size() == 0, "R4 scoreboard drained", expQ.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule